// File: doc/BRIEF.md
# Segmented Comparand Loader with Automatic Compare Request

This block assembles a wide search key for an associative lookup array from a sequence of narrow host writes. The key (the comparand) is `NUM_SEG` slices of `BUS_W` bits each, so it is 64 bits with the defaults. A segment pointer picks the slice that the next write fills. Software sets a window through two inputs: the segment where filling begins and the segment where it ends. The pointer moves through that window by one slice per write.

When a write lands on the end segment, the block raises a one-cycle compare request. The lookup array that sits beside the block uses this request to start a search. The pointer then returns to the start segment, ready for the next key.

Between writes, the host can rotate the whole comparand by one bit to the left or to the right. A rotate is circular: the bit that leaves one end comes back in at the other end. A host can use this to slide a key across bit alignments and run a new compare after each step.

Top module: `cmp_loader`

## Requirements
- R1: After reset, `comparand` is all zeros and `cmp_req` is 0. The first write after reset goes to segment `seg_first`.
- R2: A write stores `wr_data` in bits [BUS_W*s+BUS_W-1 : BUS_W*s] of `comparand`, where s is the current segment, and leaves every other bit unchanged. The new value is visible in the cycle after the write.
- R3: A write that is not on `seg_last` moves the pointer up by one segment. From segment NUM_SEG-1 the pointer wraps to segment 0.
- R4: After a write on `seg_last`, the pointer goes back to `seg_first`. The value used is whatever `seg_first` holds when the next write arrives.
- R5: `cmp_req` is 1 for exactly the cycle that follows a write on `seg_last`.
- R6: With `rot_left`=1, `rot_right`=0 and no write, the comparand rotates left by one bit: bit i moves to bit i+1, and the top bit moves to bit 0.
- R7: With `rot_right`=1, `rot_left`=0 and no write, the comparand rotates right by one bit: bit i moves to bit i-1, and bit 0 moves to the top bit.
- R8: With no write, and with the two rotate commands either both 0 or both 1, the comparand holds its value.
- R9: When a write and a rotate command arrive in the same cycle, only the write takes effect. The rotate is ignored.
- R10: Rotates, idle cycles and writes that are not on `seg_last` all leave `cmp_req` at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| wr_en | input | 1 | Write strobe for one slice |
| wr_data | input | BUS_W | Data for the current slice |
| rot_left | input | 1 | Rotate the comparand left by one bit |
| rot_right | input | 1 | Rotate the comparand right by one bit |
| seg_first | input | SEG_IDX_W | Start segment of the fill window |
| seg_last | input | SEG_IDX_W | End segment of the fill window; a write here triggers the compare request |
| comparand | output | BUS_W*NUM_SEG | Assembled comparand |
| cmp_req | output | 1 | One-cycle compare request |

## Verification
Every result here passes through exactly one register, so the slice write, the rotate and the compare request all show up in the cycle after the stimulus. The bench drives each stimulus on the falling edge. It then checks `comparand` and `cmp_req` one time unit after the next rising edge, against a model that it updates from the requirements in that same step.

The bench sweeps every pairing of start and end segment. Each pairing starts from reset and runs through more writes than the window holds, so that the wrap at NUM_SEG-1 and the return to the start segment are both exercised. Rotates, cancelled rotates and write-versus-rotate collisions are applied on top of each filled key.

// File: rtl/cmp_loader_pkg.sv
package cmp_loader_pkg;

  localparam int unsigned DEF_BUS_W   = 16;
  localparam int unsigned DEF_NUM_SEG = 4;

  // Datapath action decoded once per cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_ROTL  = 2'd2,
    ACT_ROTR  = 2'd3
  } cmp_act_e;

endpackage

// File: rtl/cmp_seg_seq.sv
module cmp_seg_seq #(
  parameter int unsigned NUM_SEG   = 4,
  parameter int unsigned SEG_IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_IDX_W-1:0] seg_first,
  input  logic [SEG_IDX_W-1:0] seg_last,
  output logic [SEG_IDX_W-1:0] seg_cur,
  output logic                 req_q
);

  localparam logic [SEG_IDX_W-1:0] SEG_TOP = SEG_IDX_W'(NUM_SEG - 1);

  logic [SEG_IDX_W-1:0] ptr_q, ptr_d;
  logic                 ptr_vld_q, ptr_vld_d;
  logic                 term_hit;
  logic                 req_d;

  // Until a pointer is held, the start limit is used live
  assign seg_cur  = ptr_vld_q ? ptr_q : seg_first;
  assign term_hit = wr_en && (seg_cur == seg_last);

  always_comb begin
    ptr_d     = ptr_q;
    ptr_vld_d = ptr_vld_q;
    req_d     = term_hit;
    if (wr_en) begin
      if (term_hit) begin
        ptr_vld_d = 1'b0;
      end else begin
        ptr_vld_d = 1'b1;
        ptr_d     = (seg_cur == SEG_TOP) ? '0 : seg_cur + SEG_IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      ptr_vld_q <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      req_q <= req_d;
      if (wr_en) begin
        ptr_q     <= ptr_d;
        ptr_vld_q <= ptr_vld_d;
      end
    end
  end

endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_loader_pkg::*;
#(
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned NUM_SEG   = 4,
  parameter int unsigned SEG_IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cmp_act_e                   act,
  input  logic [SEG_IDX_W-1:0]       seg_cur,
  input  logic [BUS_W-1:0]           wr_data,
  output logic [BUS_W*NUM_SEG-1:0]   cmp_q
);

  localparam int unsigned CMP_W = BUS_W * NUM_SEG;

  logic [CMP_W-1:0] rot_val;
  logic [CMP_W-1:0] cmp_d;
  logic             cmp_en;

  always_comb begin
    unique case (act)
      ACT_ROTL: rot_val = {cmp_q[CMP_W-2:0], cmp_q[CMP_W-1]};
      ACT_ROTR: rot_val = {cmp_q[0], cmp_q[CMP_W-1:1]};
      default:  rot_val = cmp_q;
    endcase
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_slice
    logic sel;
    assign sel = (act == ACT_WRITE) && (seg_cur == SEG_IDX_W'(s));
    assign cmp_d[s*BUS_W +: BUS_W] = sel ? wr_data : rot_val[s*BUS_W +: BUS_W];
  end

  assign cmp_en = (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

endmodule

// File: rtl/cmp_loader.sv
module cmp_loader
  import cmp_loader_pkg::*;
#(
  parameter int unsigned BUS_W     = DEF_BUS_W,
  parameter int unsigned NUM_SEG   = DEF_NUM_SEG,
  parameter int unsigned SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [BUS_W-1:0]         wr_data,
  input  logic                     rot_left,
  input  logic                     rot_right,
  input  logic [SEG_IDX_W-1:0]     seg_first,
  input  logic [SEG_IDX_W-1:0]     seg_last,
  output logic [BUS_W*NUM_SEG-1:0] comparand,
  output logic                     cmp_req
);

  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic [SEG_IDX_W-1:0] seg_cur;
  cmp_act_e             act;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  // The write wins over the rotates; opposite rotates cancel
  always_comb begin
    if (wr_en)                       act = ACT_WRITE;
    else if (rot_left && !rot_right) act = ACT_ROTL;
    else if (rot_right && !rot_left) act = ACT_ROTR;
    else                             act = ACT_HOLD;
  end

  cmp_seg_seq #(
    .NUM_SEG   (NUM_SEG),
    .SEG_IDX_W (SEG_IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .seg_first (seg_first),
    .seg_last  (seg_last),
    .seg_cur   (seg_cur),
    .req_q     (cmp_req)
  );

  cmp_datapath #(
    .BUS_W     (BUS_W),
    .NUM_SEG   (NUM_SEG),
    .SEG_IDX_W (SEG_IDX_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .act     (act),
    .seg_cur (seg_cur),
    .wr_data (wr_data),
    .cmp_q   (comparand)
  );

endmodule

// File: rtl/cmp_loader_chk.sv
module cmp_loader_chk #(
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned NUM_SEG   = 4,
  parameter int unsigned SEG_IDX_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rot_left,
  input logic                     rot_right,
  input logic [SEG_IDX_W-1:0]     seg_first,
  input logic [SEG_IDX_W-1:0]     seg_last,
  input logic [SEG_IDX_W-1:0]     seg_cur,
  input logic [BUS_W*NUM_SEG-1:0] comparand,
  input logic                     cmp_req
);

  localparam int unsigned CMP_W = BUS_W * NUM_SEG;

  logic [SEG_IDX_W-1:0] seg_step;
  assign seg_step = (seg_cur == SEG_IDX_W'(NUM_SEG - 1)) ? '0 : seg_cur + SEG_IDX_W'(1);

  // R3
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seg_cur != seg_last) |=> (seg_cur == $past(seg_step)));

  // R4
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seg_cur == seg_last) |=> (seg_cur == seg_first));

  // R5
  a_r5_req_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seg_cur == seg_last) |=> cmp_req);

  // R10
  a_r10_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && seg_cur == seg_last) |=> !cmp_req);

  // R6
  a_r6_rot_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rot_left && !rot_right) |=>
      (comparand == {$past(comparand[CMP_W-2:0]), $past(comparand[CMP_W-1])}));

  // R7
  a_r7_rot_right: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rot_right && !rot_left) |=>
      (comparand == {$past(comparand[0]), $past(comparand[CMP_W-1:1])}));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (rot_left == rot_right)) |=> $stable(comparand));

endmodule

bind cmp_loader cmp_loader_chk #(
  .BUS_W     (BUS_W),
  .NUM_SEG   (NUM_SEG),
  .SEG_IDX_W (SEG_IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .rot_left  (rot_left),
  .rot_right (rot_right),
  .seg_first (seg_first),
  .seg_last  (seg_last),
  .seg_cur   (seg_cur),
  .comparand (comparand),
  .cmp_req   (cmp_req)
);

// File: tb/test_cmp_loader.sv
module test_cmp_loader;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned BW  = 16;
  localparam int unsigned NS  = 4;
  localparam int unsigned IW  = 2;
  localparam int unsigned CW  = BW * NS;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [BW-1:0] wr_data;
  logic          rot_left, rot_right;
  logic [IW-1:0] seg_first, seg_last;
  logic [CW-1:0] comparand;
  logic          cmp_req;

  int total = 0;
  int bad   = 0;

  logic [CW-1:0] m_cmp;
  logic [IW-1:0] m_ptr;
  logic          m_vld;
  logic          m_req;

  cmp_loader i_cmp_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rot_left  (rot_left),
    .rot_right (rot_right),
    .seg_first (seg_first),
    .seg_last  (seg_last),
    .comparand (comparand),
    .cmp_req   (cmp_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_cmp(input string tag);
    total++;
    if (comparand !== m_cmp) begin
      bad++;
      $display("FAIL %s comparand actual=%h expected=%h", tag, comparand, m_cmp);
    end
  endtask

  task automatic chk_req(input string tag);
    total++;
    if (cmp_req !== m_req) begin
      bad++;
      $display("FAIL %s cmp_req actual=%b expected=%b", tag, cmp_req, m_req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rot_left = 1'b0; rot_right = 1'b0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cmp = '0; m_vld = 1'b0; m_ptr = '0; m_req = 1'b0;
    chk_cmp("R1"); chk_req("R1");
  endtask

  // One cycle of stimulus, model update and check one register later
  task automatic cyc(input logic w, input logic [BW-1:0] d,
                     input logic rl, input logic rr, input string tag);
    logic [IW-1:0] s;
    @(negedge clk);
    wr_en = w; wr_data = d; rot_left = rl; rot_right = rr;
    s = m_vld ? m_ptr : seg_first;
    m_req = 1'b0;
    if (w) begin
      m_cmp[s*BW +: BW] = d;
      if (s == seg_last) begin
        m_vld = 1'b0; m_req = 1'b1;
      end else begin
        m_vld = 1'b1;
        m_ptr = IW'((int'(s) + 1) % NS);
      end
    end else if (rl && !rr) begin
      m_cmp = {m_cmp[CW-2:0], m_cmp[CW-1]};
    end else if (rr && !rl) begin
      m_cmp = {m_cmp[0], m_cmp[CW-1:1]};
    end
    @(posedge clk);
    #1;
    chk_cmp(tag);
    chk_req(w ? "R5" : "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    rot_left = 1'b0; rot_right = 1'b0; seg_first = '0; seg_last = '0;
    for (int f = 0; f < NS; f++) begin
      for (int l = 0; l < NS; l++) begin
        seg_first = IW'(f);
        seg_last  = IW'(l);
        do_reset();
        // R2 R3 R4: fill past the window so both the wrap and the reload occur
        for (int k = 0; k < 2 * NS + 1; k++) begin
          cyc(1'b1, BW'(16'h1357 * (k + 1) ^ (f << 12) ^ (l << 8)), 1'b0, 1'b0, "R2_R3_R4");
        end
        // R6 and R7
        for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R6");
        for (int k = 0; k < 5; k++) cyc(1'b0, '0, 1'b0, 1'b1, "R7");
        // R8
        cyc(1'b0, BW'(16'hFFFF), 1'b1, 1'b1, "R8");
        cyc(1'b0, BW'(16'hFFFF), 1'b0, 1'b0, "R8");
        // R9
        cyc(1'b1, BW'(16'hC3A5 ^ f), 1'b1, 1'b0, "R9");
        cyc(1'b1, BW'(16'h5A3C ^ l), 1'b0, 1'b1, "R9");
        cyc(1'b0, '0, 1'b0, 1'b0, "R8");
      end
    end
    // R4: start limit changed after a terminal write is used live
    seg_first = 2'd0; seg_last = 2'd1;
    do_reset();
    cyc(1'b1, 16'hAAAA, 1'b0, 1'b0, "R2");
    cyc(1'b1, 16'hBBBB, 1'b0, 1'b0, "R5");
    seg_first = 2'd3;
    cyc(1'b1, 16'hCCCC, 1'b0, 1'b0, "R4");
    cyc(1'b1, 16'hDDDD, 1'b0, 1'b0, "R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule